// File: doc/BRIEF.md
# Hitless Resumable Counter Output Stage

This block is a small binary counter whose value drives a set of output pins that must stay steady while the logic behind them is replaced. A per-bit 2:1 hold selector sits between the counter and the pins. While the run enable is high, the pins show the live count. While it is low, the pins show one of two values, chosen by the resume-mode input. With resume mode off, they show the power-up value of zero. With resume mode on, they show the value read back from the pins themselves, so the pins keep whatever they last displayed.

The resume-mode input also decides what the asynchronous reset loads into the counter: zero, or the pin readback. A reloaded design can therefore carry on counting from the value held across the update, instead of starting over. The hold selector is pure combinational logic, so it already steers the pins correctly while reset is still asserted.

The counting direction is a build parameter. The original build counts up, and the replacement build counts down on the same ports. A prescaler parameter sets how many clocks pass between steps.

Top module: `hitless_counter`

## Requirements
- R1: With COUNT_DOWN = 0, each prescaler tick taken while run_en is 1 adds one to the count, and the count wraps from 255 to 0.
- R2: With COUNT_DOWN = 1, each prescaler tick taken while run_en is 1 subtracts one from the count, and the count wraps from 0 to 255.
- R3: While run_en is 1, pin_drv equals the live count, whatever the value of resume_en.
- R4: While run_en is 0 and resume_en is 0, pin_drv is all zeros and the count is cleared at each clock, so counting restarts from 0.
- R5: While run_en is 0 and resume_en is 1, pin_drv equals pin_fb and the count loads pin_fb at each clock, so counting resumes from the held pin value.
- R6: While rst_n is 0, the count is loaded with zero if resume_en is 0, or with pin_fb if resume_en is 1.
- R7: The hold selection depends only on run_en and resume_en, with no register in its path, so pin_drv equals pin_fb during reset when run_en is 0 and resume_en is 1.
- R8: With TICK_DIV = N > 1, the count steps once every N clocks of continuous run_en. The prescaler restarts when run_en is 0 or rst_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| resume_en | input | 1 | 1 selects the hold/resume mode, 0 selects the power-up mode |
| run_en | input | 1 | 1 lets the counter run and drive the pins |
| pin_fb | input | WIDTH | Value currently present on the output pins |
| pin_drv | output | WIDTH | Value to drive onto the pins |

## Verification
The bench builds three copies that share their controls:
- an up-counting copy and a down-counting copy, both with TICK_DIV = 1, so every clock gives one step and both wrap points are reached within a few hundred cycles;
- an up-counting copy with TICK_DIV = 3, which shows that the prescaler paces the steps and restarts after a freeze.

Each copy has its own pin register, which copies pin_drv unless a pad-hold flag is set. This gives the freeze, reset and resume sequence a real feedback path. The bench checks that the pin value is the same before, during and after a reset taken in resume mode.

// File: rtl/hitless_counter.sv
module hitless_counter #(
  parameter int WIDTH      = 8,
  parameter bit COUNT_DOWN = 1'b0,
  parameter int TICK_DIV   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resume_en,
  input  logic             run_en,
  input  logic [WIDTH-1:0] pin_fb,
  output logic [WIDTH-1:0] pin_drv
);

  localparam logic [WIDTH-1:0] STEP = COUNT_DOWN ? {WIDTH{1'b1}} : WIDTH'(1);

  logic [WIDTH-1:0] cnt;
  logic             tick;

  generate
    if (TICK_DIV <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pre <= '0;
        else if (!run_en)     pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                  pre <= pre + PW'(1);
      end
      assign tick = (pre == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= resume_en ? pin_fb : '0;
    else if (run_en)    cnt <= tick ? cnt + STEP : cnt;
    else if (resume_en) cnt <= pin_fb;
    else                cnt <= '0;
  end

  assign pin_drv = run_en ? cnt : (resume_en ? pin_fb : '0);

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick) |=> (cnt == WIDTH'($past(cnt) + STEP))); // R1 R2
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !resume_en) |=> (cnt == '0)); // R4
  AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && resume_en) |=> (cnt == $past(pin_fb))); // R5
  AST_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick) |=> $stable(cnt)); // R8

endmodule

// File: tb/sim_hitless_counter.sv
module sim_hitless_counter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resume_en = 1'b0;
  logic run_en = 1'b0;
  logic pad_hold = 1'b0;
  logic [W-1:0] pad0 = '0, pad1 = '0, pad2 = '0;
  logic [W-1:0] drv0, drv1, drv2;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hitless_counter #(.WIDTH(W), .COUNT_DOWN(1'b0), .TICK_DIV(1)) u0 (
    .clk(clk), .rst_n(rst_n), .resume_en(resume_en), .run_en(run_en),
    .pin_fb(pad0), .pin_drv(drv0));
  hitless_counter #(.WIDTH(W), .COUNT_DOWN(1'b1), .TICK_DIV(1)) u1 (
    .clk(clk), .rst_n(rst_n), .resume_en(resume_en), .run_en(run_en),
    .pin_fb(pad1), .pin_drv(drv1));
  hitless_counter #(.WIDTH(W), .COUNT_DOWN(1'b0), .TICK_DIV(3)) u2 (
    .clk(clk), .rst_n(rst_n), .resume_en(resume_en), .run_en(run_en),
    .pin_fb(pad2), .pin_drv(drv2));

  always @(negedge clk) begin
    if (!pad_hold) begin
      pad0 <= drv0;
      pad1 <= drv1;
      pad2 <= drv2;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_slot();
    @(negedge clk); #4;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic t_reset_clear();
    #1;
    check("R6 up reset clear", drv0, 8'd0);
    check("R6 down reset clear", drv1, 8'd0);
    run_en = 1'b1; #1;
    check("R3 output is count in reset", drv0, 8'd0);
    run_en = 1'b0;
    drive_slot();
    rst_n = 1'b1;
  endtask

  task automatic t_count();
    drive_slot();
    run_en = 1'b1;
    step(5);
    check("R1 up count", drv0, 8'd5);
    check("R2 down wrap and count", drv1, 8'd251);
    check("R8 divided count", drv2, 8'd1);
    drive_slot();
    resume_en = 1'b1;
    step(1);
    check("R3 up ignores resume_en", drv0, 8'd6);
    check("R3 down ignores resume_en", drv1, 8'd250);
    check("R8 third tick", drv2, 8'd2);
  endtask

  task automatic t_update();
    drive_slot();
    run_en = 1'b0; #1;
    check("R5 freeze up", drv0, 8'd6);
    check("R5 freeze down", drv1, 8'd250);
    step(3);
    check("R5 held up", drv0, 8'd6);
    check("R5 held down", drv1, 8'd250);
    drive_slot();
    pad_hold = 1'b1;
    rst_n = 1'b0; #1;
    check("R7 held in reset up", drv0, 8'd6);
    check("R7 held in reset down", drv1, 8'd250);
    check("R7 held in reset div", drv2, 8'd2);
    step(2);
    drive_slot();
    rst_n = 1'b1;
    step(1);
    check("R6 after reload up", drv0, 8'd6);
    drive_slot();
    pad_hold = 1'b0;
    run_en = 1'b1;
    step(1);
    check("R5 resume up", drv0, 8'd7);
    check("R5 resume down", drv1, 8'd249);
    check("R8 prescaler restarted", drv2, 8'd2);
    step(2);
    check("R8 step after restart", drv2, 8'd3);
  endtask

  task automatic t_zero_hold();
    drive_slot();
    run_en = 1'b0;
    resume_en = 1'b0; #1;
    check("R4 zero output up", drv0, 8'd0);
    check("R4 zero output down", drv1, 8'd0);
    step(1);
    drive_slot();
    run_en = 1'b1;
    step(1);
    check("R4 restart up", drv0, 8'd1);
    check("R2 restart down wraps", drv1, 8'd255);
  endtask

  task automatic t_wrap();
    step(255);
    check("R1 up wrap", drv0, 8'd0);
    check("R2 down reaches zero", drv1, 8'd0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_clear();
    t_count();
    t_update();
    t_zero_hold();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule